// File: doc/BRIEF.md
# UART Receive Release Controller

This block sits between a UART receive FIFO and a USB bulk IN endpoint. It decides when the buffered receive bytes go to the host and how many go in each packet. The FIFO storage, the receiver and the USB engine stay outside the block. The block sees the FIFO only as a fill count and a byte-arrival strobe. It sees the endpoint only as a request strobe and a packet-sent handshake.

In batching mode, bytes are held until a full 64-byte packet has gathered. They are also released when the line has been idle for three character times. In low-latency mode, every request that finds data gets that data. An 8-bit control register selects the mode. Low-latency mode is forced on whenever a baud update reports a rate below 46921 bps.

Top module: `rx_release_ctrl`

## Requirements
- R1: In batching mode, a request that finds 64 or more bytes buffered is granted with a count of exactly 64.
- R2: `release_ready_o` rises exactly 3 × `char_cycles_i` clock edges after the last sampled `byte_in_i`, provided the fill is non-zero. It stays low before that edge. Any new `byte_in_i` clears it and restarts the count.
- R3: In low-latency mode, a request that finds between 1 and 63 bytes is granted with a count equal to the fill.
- R4: Every request produces exactly one of `grant_o` or `nak_o`, one cycle after the edge that sampled it. The grant count equals min(fill, 64) and is never zero.
- R5: In batching mode, a request is answered with `nak_o` when the fill is below 64 and no idle timeout has occurred.
- R6: A request that finds a fill of zero is answered with `nak_o` in every mode, including after a timeout.
- R7: Control register bit 0 holds the low-latency setting. Bits 7:1 always read as zero, and writes to them have no effect.
- R8: A baud update with `baud_i` below 46921 sets bit 0 to 1, and later writes cannot clear it. A baud update at or above 46921 sets bit 0 to 0, and later writes then set it freely. When a write and a baud update occur in the same cycle, the baud update wins.
- R9: After a grant, every request is answered with `nak_o` until `pkt_sent_i`. `pkt_sent_i` clears the timeout. The idle count then restarts from zero, and it runs only while the fill is non-zero.
- R10: After reset, all outputs are zero and bit 0 of the control register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data |
| cfg_rdata_o | output | 8 | Control register read value |
| baud_upd_i | input | 1 | Baud setting changed strobe |
| baud_i | input | BAUD_W | Configured baud rate in bps |
| char_cycles_i | input | CHAR_W | Clock cycles per character time |
| fill_i | input | FILL_W | Current FIFO fill level in bytes |
| byte_in_i | input | 1 | A received byte entered the FIFO |
| req_i | input | 1 | Host bulk IN request strobe |
| pkt_sent_i | input | 1 | Granted packet has been sent |
| grant_o | output | 1 | Release granted (one-cycle pulse) |
| nak_o | output | 1 | No-data answer (one-cycle pulse) |
| grant_cnt_o | output | CNT_W | Byte count of the granted packet |
| release_ready_o | output | 1 | A release condition currently holds |

## Verification
A request's answer, `grant_o` or `nak_o`, together with `grant_cnt_o`, is due one clock edge after the edge that samples `req_i`. The bench drives inputs on the falling edge and reads the answer on the next falling edge. Control register effects show on `cfg_rdata_o` one edge after the write or baud strobe, and they are read at the same falling edge. The timeout is checked at two edges: one edge before the 3 × `char_cycles_i` edge, where it must still be low, and on that edge, where it must be high. The edges are counted from the edge that sampled the last byte strobe or packet-sent strobe.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  localparam int unsigned PKT_MAX_BYTES = 64;
  localparam int unsigned IDLE_CHARS    = 3;
  localparam int unsigned LL_BAUD_MIN   = 46921;
endpackage

// File: rtl/rrc_cfg_reg.sv
module rrc_cfg_reg #(
  parameter int unsigned BAUD_W      = 24,
  parameter int unsigned LL_BAUD_MIN = rrc_pkg::LL_BAUD_MIN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              baud_upd_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              ll_o
);
  logic slow_q, ll_q, slow_n;
  logic unused_wdata;

  assign slow_n       = baud_i < BAUD_W'(LL_BAUD_MIN);
  assign unused_wdata = ^wdata_i[7:1];

  // baud update has priority over a same-cycle write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slow_q <= 1'b0;
      ll_q   <= 1'b0;
    end else if (baud_upd_i) begin
      slow_q <= slow_n;
      ll_q   <= slow_n;
    end else if (we_i) begin
      ll_q   <= wdata_i[0] | slow_q;
    end
  end

  assign rdata_o = {7'b0, ll_q};
  assign ll_o    = ll_q;
endmodule

// File: rtl/rrc_idle_timer.sv
module rrc_idle_timer #(
  parameter int unsigned CHAR_W    = 16,
  parameter int unsigned IDLE_CHARS = rrc_pkg::IDLE_CHARS,
  localparam int unsigned CHR_W    = $clog2(IDLE_CHARS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHAR_W-1:0] char_cycles_i,
  input  logic              fill_nz_i,
  input  logic              restart_i,
  output logic              timeout_o
);
  logic [CHAR_W-1:0] cyc_q;
  logic [CHR_W-1:0]  chr_q;
  logic              to_q;
  logic              run, wrap;

  assign run  = fill_nz_i && !to_q && !restart_i;
  // a zero setting behaves as one cycle per character
  assign wrap = ({1'b0, cyc_q} + 1'b1) >= {1'b0, char_cycles_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      chr_q <= '0;
      to_q  <= 1'b0;
    end else if (restart_i) begin
      cyc_q <= '0;
      chr_q <= '0;
      to_q  <= 1'b0;
    end else if (run) begin
      if (wrap) begin
        cyc_q <= '0;
        chr_q <= chr_q + 1'b1;
        if (chr_q + 1'b1 == CHR_W'(IDLE_CHARS)) to_q <= 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  assign timeout_o = to_q;
endmodule

// File: rtl/rrc_grant_ctl.sv
module rrc_grant_ctl #(
  parameter int unsigned FILL_W  = 8,
  parameter int unsigned PKT_MAX = rrc_pkg::PKT_MAX_BYTES,
  localparam int unsigned CNT_W  = $clog2(PKT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FILL_W-1:0] fill_i,
  input  logic              req_i,
  input  logic              ll_i,
  input  logic              timeout_i,
  input  logic              pkt_sent_i,
  output logic              grant_o,
  output logic              nak_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              ready_o
);
  logic             busy_q, grant_q, nak_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             full, fill_nz;

  assign fill_nz = fill_i != '0;
  assign full    = fill_i >= FILL_W'(PKT_MAX);
  assign ready_o = fill_nz && (ll_i || full || timeout_i);
  assign cnt_n   = full ? CNT_W'(PKT_MAX) : CNT_W'(fill_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      grant_q <= 1'b0;
      nak_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      grant_q <= 1'b0;
      nak_q   <= 1'b0;
      if (pkt_sent_i) busy_q <= 1'b0;
      if (req_i) begin
        if (!busy_q && ready_o) begin
          grant_q <= 1'b1;
          cnt_q   <= cnt_n;
          busy_q  <= 1'b1;
        end else begin
          nak_q   <= 1'b1;
        end
      end
    end
  end

  assign grant_o = grant_q;
  assign nak_o   = nak_q;
  assign cnt_o   = grant_q ? cnt_q : '0;
endmodule

// File: rtl/rx_release_ctrl.sv
module rx_release_ctrl #(
  parameter int unsigned FILL_W      = 8,
  parameter int unsigned CHAR_W      = 16,
  parameter int unsigned BAUD_W      = 24,
  parameter int unsigned PKT_MAX     = rrc_pkg::PKT_MAX_BYTES,
  parameter int unsigned IDLE_CHARS  = rrc_pkg::IDLE_CHARS,
  parameter int unsigned LL_BAUD_MIN = rrc_pkg::LL_BAUD_MIN,
  localparam int unsigned CNT_W      = $clog2(PKT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [7:0]        cfg_wdata_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic              baud_upd_i,
  input  logic [BAUD_W-1:0] baud_i,
  input  logic [CHAR_W-1:0] char_cycles_i,
  input  logic [FILL_W-1:0] fill_i,
  input  logic              byte_in_i,
  input  logic              req_i,
  input  logic              pkt_sent_i,
  output logic              grant_o,
  output logic              nak_o,
  output logic [CNT_W-1:0]  grant_cnt_o,
  output logic              release_ready_o
);
  logic ll, timeout;

  rrc_cfg_reg #(.BAUD_W(BAUD_W), .LL_BAUD_MIN(LL_BAUD_MIN)) u_cfg (
    .clk_i, .rst_ni,
    .baud_upd_i, .baud_i,
    .we_i(cfg_we_i), .wdata_i(cfg_wdata_i),
    .rdata_o(cfg_rdata_o), .ll_o(ll)
  );

  rrc_idle_timer #(.CHAR_W(CHAR_W), .IDLE_CHARS(IDLE_CHARS)) u_timer (
    .clk_i, .rst_ni,
    .char_cycles_i,
    .fill_nz_i(fill_i != '0),
    .restart_i(byte_in_i | pkt_sent_i),
    .timeout_o(timeout)
  );

  rrc_grant_ctl #(.FILL_W(FILL_W), .PKT_MAX(PKT_MAX)) u_grant (
    .clk_i, .rst_ni,
    .fill_i, .req_i,
    .ll_i(ll), .timeout_i(timeout), .pkt_sent_i,
    .grant_o, .nak_o, .cnt_o(grant_cnt_o),
    .ready_o(release_ready_o)
  );
endmodule

// File: rtl/rx_release_ctrl_chk.sv
module rx_release_ctrl_chk #(
  parameter int unsigned FILL_W      = 8,
  parameter int unsigned BAUD_W      = 24,
  parameter int unsigned PKT_MAX     = 64,
  parameter int unsigned LL_BAUD_MIN = 46921,
  parameter int unsigned CNT_W       = 7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [FILL_W-1:0] fill_i,
  input logic              baud_upd_i,
  input logic [BAUD_W-1:0] baud_i,
  input logic              grant_o,
  input logic              nak_o,
  input logic [CNT_W-1:0]  grant_cnt_o,
  input logic [7:0]        cfg_rdata_o
);
  // R4
  grant_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o || nak_o) |-> $past(req_i));
  // R4
  one_answer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, nak_o}));
  // R4
  grant_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (grant_cnt_o != '0) && (grant_cnt_o <= CNT_W'(PKT_MAX))
                && ({{FILL_W{1'b0}}, grant_cnt_o} <= {{CNT_W{1'b0}}, $past(fill_i)}));
  // R6
  empty_nak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && fill_i == '0) |=> nak_o);
  // R7
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[7:1] == 7'b0);
  // R8
  slow_baud_forces_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (baud_upd_i && baud_i < BAUD_W'(LL_BAUD_MIN)) |=> cfg_rdata_o[0]);
endmodule

bind rx_release_ctrl rx_release_ctrl_chk #(
  .FILL_W(FILL_W), .BAUD_W(BAUD_W), .PKT_MAX(PKT_MAX),
  .LL_BAUD_MIN(LL_BAUD_MIN), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .fill_i(fill_i),
  .baud_upd_i(baud_upd_i), .baud_i(baud_i), .grant_o(grant_o),
  .nak_o(nak_o), .grant_cnt_o(grant_cnt_o), .cfg_rdata_o(cfg_rdata_o)
);

// File: tb/rx_release_ctrl_test.sv
module rx_release_ctrl_test;
  localparam int FILL_W = 8, CHAR_W = 16, BAUD_W = 24, CNT_W = 7, CH = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_we = 1'b0, baud_upd = 1'b0, byte_in = 1'b0, req = 1'b0, pkt_sent = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic [BAUD_W-1:0] baud = 24'd115200;
  logic [CHAR_W-1:0] char_cycles = CHAR_W'(CH);
  logic [FILL_W-1:0] fill = '0;
  logic grant, nak, ready;
  logic [CNT_W-1:0] gcnt;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  rx_release_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .baud_upd_i(baud_upd), .baud_i(baud),
    .char_cycles_i(char_cycles), .fill_i(fill), .byte_in_i(byte_in),
    .req_i(req), .pkt_sent_i(pkt_sent), .grant_o(grant), .nak_o(nak),
    .grant_cnt_o(gcnt), .release_ready_o(ready)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_cnt(int f);
    return (f >= 64) ? 64 : f;
  endfunction

  // 1 = grant, 2 = nak
  task automatic request(string tag, int exp_kind, int exp_n);
    req = 1'b1; step(); req = 1'b0;
    chk({tag, " kind"}, grant ? 1 : (nak ? 2 : 0), exp_kind);
    if (exp_kind == 1) chk({tag, " count"}, int'(gcnt), exp_n);
  endtask

  task automatic wr(logic [7:0] d);
    cfg_we = 1'b1; cfg_wdata = d; step(); cfg_we = 1'b0;
  endtask

  task automatic set_baud(int b);
    baud_upd = 1'b1; baud = BAUD_W'(b); step(); baud_upd = 1'b0;
  endtask

  task automatic sent(int new_fill);
    pkt_sent = 1'b1; fill = FILL_W'(new_fill); step(); pkt_sent = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    step(2);
    // R10 reset state
    chk("R10 grant", int'(grant), 0);
    chk("R10 nak", int'(nak), 0);
    chk("R10 ready", int'(ready), 0);
    chk("R10 rdata", int'(cfg_rdata), 0);
    rst_ni = 1'b1; step();

    // R7 register bits
    set_baud(115200);
    wr(8'hFE); chk("R7 reserved ignored", int'(cfg_rdata), 0);
    wr(8'h01); chk("R7 bit0 set", int'(cfg_rdata), 1);
    wr(8'hFF); chk("R7 read mask", int'(cfg_rdata), 1);
    wr(8'h00); chk("R7 bit0 clear", int'(cfg_rdata), 0);

    // R8 slow baud forcing
    set_baud(46920); chk("R8 forced", int'(cfg_rdata), 1);
    wr(8'h00); chk("R8 write blocked", int'(cfg_rdata), 1);
    set_baud(46921); chk("R8 threshold clears", int'(cfg_rdata), 0);
    wr(8'h01); chk("R8 free write", int'(cfg_rdata), 1);
    cfg_we = 1'b1; cfg_wdata = 8'h00; baud_upd = 1'b1; baud = 24'd9600; step();
    cfg_we = 1'b0; baud_upd = 1'b0;
    chk("R8 baud wins", int'(cfg_rdata), 1);
    set_baud(115200); chk("R8 reevaluated", int'(cfg_rdata), 0);

    // R1 / R5 batching mode
    fill = 8'd63; byte_in = 1'b1; step(); byte_in = 1'b0;
    request("R5 below threshold", 2, 0);
    fill = 8'd64; byte_in = 1'b1; step(); byte_in = 1'b0;
    request("R1 full packet", 1, 64);
    request("R9 busy", 2, 0);
    sent(100);
    request("R1 over threshold", 1, 64);
    sent(36);

    // R2 timeout timing, R9 re-arm
    fill = 8'd5; byte_in = 1'b1; step(); byte_in = 1'b0;
    step(3*CH - 1); chk("R2 not yet", int'(ready), 0);
    step(); chk("R2 timeout edge", int'(ready), 1);
    request("R2 timeout grant", 1, 5);
    request("R9 busy after timeout", 2, 0);
    sent(3); chk("R9 timeout cleared", int'(ready), 0);
    step(3*CH - 1); chk("R9 rearm early", int'(ready), 0);
    step(); chk("R9 rearm fires", int'(ready), 1);
    byte_in = 1'b1; step(); byte_in = 1'b0;
    chk("R2 byte clears", int'(ready), 0);
    step(6); byte_in = 1'b1; step(); byte_in = 1'b0;
    step(3*CH - 1); chk("R2 restart early", int'(ready), 0);
    step(); chk("R2 restart fires", int'(ready), 1);
    fill = 8'd0; step();
    request("R6 empty after timeout", 2, 0);
    sent(0); step(3*CH + 2);
    chk("R9 no rearm when empty", int'(ready), 0);

    // R3 / R6 low-latency
    set_baud(9600);
    fill = 8'd1; request("R3 single byte", 1, 1); sent(0);
    request("R6 empty low latency", 2, 0);

    // random mix: R1 R3 R4 R5 R6
    for (int i = 0; i < 60; i++) begin
      automatic int f = $urandom_range(0, 130);
      automatic bit ll = $urandom_range(0, 1) == 1;
      set_baud(ll ? 19200 : 230400);
      fill = FILL_W'(f); byte_in = 1'b1; step(); byte_in = 1'b0;
      if (f == 0) request("R6 random", 2, 0);
      else if (ll || f >= 64) request("R4 random", 1, exp_cnt(f));
      else request("R5 random", 2, 0);
      if (grant) sent(f - exp_cnt(f));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule